// File: doc/BRIEF.md
# Pin Interrupt Detector for an Eight-Pin Port

This block watches the eight input pins of a general-purpose port and raises an interrupt when a pin shows the event that software chose for it. Each pin has its own trigger choice: a high level, a low level, a rising edge, a falling edge, or any edge. The pins first pass through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one taken a cycle earlier.

Three per-pin configuration registers (sense, any-edge and polarity) select the trigger. A fourth register, the enable mask, decides which pins may reach the combined interrupt line. Edge events are held in a per-pin latch. That latch is a two-state machine. PIN_IDLE moves to PIN_PENDING on a detected edge. PIN_PENDING moves back to PIN_IDLE on a write-one-to-clear acknowledgement that is not met by a new edge in the same cycle. A level-sensitive pin holds its latch in PIN_IDLE, and its raw status follows the synchronized level directly.

Software reaches everything through a simple register bus. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational on `bus_addr`.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the sense, any-edge, polarity and enable registers read 0, raw and masked status read 0, and `irq` is low.
- R2: A pin whose sense bit is 1 is level-sensitive. Its raw status is 1 while the synchronized level equals its polarity bit (1 = high, 0 = low). Writing the clear register does not remove it while the level persists.
- R3: A pin with sense 0, any-edge 0 and polarity 1 latches its raw status on a 0-to-1 transition only.
- R4: A pin with sense 0, any-edge 0 and polarity 0 latches its raw status on a 1-to-0 transition only.
- R5: A pin with sense 0 and any-edge 1 latches on either transition, whatever its polarity bit.
- R6: Masked status equals raw status AND the enable register. `irq` is 1 exactly when any masked bit is 1.
- R7: Writing the clear register clears the latched edge flag of each pin whose data bit is 1 and leaves the others unchanged. An uncleared flag stays set.
- R8: An edge detected in the same cycle as a clear write for that pin leaves the flag set.
- R9: A pin change sampled at clock edge k shows in level raw status after edge k+1 and in edge raw status after edge k+2, not earlier.
- R10: Register map (3-bit address, bit i = pin i): 0 sense, 1 any-edge, 2 polarity, 3 enable (read/write); 4 raw status and 5 masked status (read-only, writes ignored); 6 clear (write-only, reads 0); 7 synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 8 | Asynchronous pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| irq | output | 1 | Combined interrupt, OR of masked status |

## Verification
All five trigger modes are swept against four pin-transition patterns: all rising, all falling, and two mixed patterns. Together these separate rising from falling from any-edge detection, and level-high from level-low. A mixed per-pin configuration shows that each pin decodes its own bits. Single-bit and sparse enable masks show that masked status and `irq` follow the enable register bit by bit. Cycle-exact probes cover the synchronizer latency, a partial clear, a clear that meets an edge in the same cycle, and a clear attempted on a held level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_SENSE  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_ANY    = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_POL    = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_ENABLE = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_RAW    = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_MASKED = 3'd5;
    localparam logic [REG_AW-1:0] ADDR_CLEAR  = 3'd6;
    localparam logic [REG_AW-1:0] ADDR_LEVEL  = 3'd7;

    typedef enum logic {
        PIN_IDLE    = 1'b0,
        PIN_PENDING = 1'b1
    } pin_state_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] pin_cur,
    output logic [NPINS-1:0] pin_prev
);
    logic [NPINS-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            pin_cur  <= '0;
            pin_prev <= '0;
        end else begin
            stage1   <= pin_async;
            pin_cur  <= stage1;
            pin_prev <= pin_cur;
        end
    end

    // R9: the synchronized level only moves to what the first stage held
    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cur != $past(pin_cur)) |-> (pin_cur == $past(stage1)));
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_sens,
    input  logic any_edge,
    input  logic polarity,
    input  logic cur,
    input  logic prev,
    input  logic clr,
    output logic raw
);
    pin_state_e state_q, state_d;
    logic rise, fall, edge_hit, level_match;

    always_comb begin
        rise        = cur & ~prev;
        fall        = ~cur & prev;
        edge_hit    = any_edge ? (rise | fall) : (polarity ? rise : fall);
        level_match = (cur == polarity);
    end

    always_comb begin
        state_d = state_q;
        if (level_sens) begin
            state_d = PIN_IDLE;
        end else begin
            unique case (state_q)
                PIN_IDLE:    if (edge_hit) state_d = PIN_PENDING;
                PIN_PENDING: if (clr && !edge_hit) state_d = PIN_IDLE;
                default:     state_d = PIN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        raw = level_sens ? level_match : (state_q == PIN_PENDING);
    end

    // R8: a detected edge always leaves the latch pending, clear or not
    assert_edge_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_sens && edge_hit) |=> (state_q == PIN_PENDING));
    // R7: a pending flag without a clear stays pending
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_sens && state_q == PIN_PENDING && !clr) |=> (state_q == PIN_PENDING));
    // R7: a clear with no coinciding edge drops the flag
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_sens && clr && !edge_hit) |=> (state_q == PIN_IDLE));
    // R2: the latch is parked while the pin is level-sensitive
    assert_level_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level_sens |=> (state_q == PIN_IDLE));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  raw,
    input  logic [NPINS-1:0]  masked,
    input  logic [NPINS-1:0]  level,
    output logic [NPINS-1:0]  sense,
    output logic [NPINS-1:0]  any_edge,
    output logic [NPINS-1:0]  polarity,
    output logic [NPINS-1:0]  enable,
    output logic [NPINS-1:0]  clr,
    output logic [NPINS-1:0]  bus_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense    <= '0;
            any_edge <= '0;
            polarity <= '0;
            enable   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADDR_SENSE:  sense    <= bus_wdata;
                ADDR_ANY:    any_edge <= bus_wdata;
                ADDR_POL:    polarity <= bus_wdata;
                ADDR_ENABLE: enable   <= bus_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        clr = (bus_wr && bus_addr == ADDR_CLEAR) ? bus_wdata : '0;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_SENSE:  bus_rdata = sense;
            ADDR_ANY:    bus_rdata = any_edge;
            ADDR_POL:    bus_rdata = polarity;
            ADDR_ENABLE: bus_rdata = enable;
            ADDR_RAW:    bus_rdata = raw;
            ADDR_MASKED: bus_rdata = masked;
            ADDR_CLEAR:  bus_rdata = '0;
            ADDR_LEVEL:  bus_rdata = level;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_async,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq
);
    logic [NPINS-1:0] pin_cur, pin_prev;
    logic [NPINS-1:0] sense, any_edge, polarity, enable, clr;
    logic [NPINS-1:0] raw, masked;

    gpio_irq_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .pin_cur(pin_cur), .pin_prev(pin_prev)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .raw(raw), .masked(masked), .level(pin_cur),
        .sense(sense), .any_edge(any_edge), .polarity(polarity),
        .enable(enable), .clr(clr), .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk(clk), .rst_n(rst_n),
            .level_sens(sense[i]), .any_edge(any_edge[i]), .polarity(polarity[i]),
            .cur(pin_cur[i]), .prev(pin_prev[i]), .clr(clr[i]), .raw(raw[i])
        );
    end

    always_comb begin
        masked = raw & enable;
        irq    = |masked;
    end

    // R6: the masked status read back over the bus matches raw AND enable
    assert_masked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_MASKED) |-> (bus_rdata == (raw & enable)));
    // R6: with every pin disabled the interrupt line stays low
    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_async = '0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h expected=%02h", req, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] expect_raw(input logic [7:0] s, input logic [7:0] b,
                                              input logic [7:0] p, input logic [7:0] from,
                                              input logic [7:0] to);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (s[i]) r[i] = (to[i] == p[i]);
            else if (b[i]) r[i] = (to[i] != from[i]);
            else if (p[i]) r[i] = to[i] & ~from[i];
            else r[i] = ~to[i] & from[i];
        end
        return r;
    endfunction

    task automatic run_case(input string req, input logic [7:0] s, input logic [7:0] b,
                            input logic [7:0] p, input logic [7:0] from, input logic [7:0] to);
        logic [7:0] v;
        pin_async = from;
        idle(4);
        wr(3'd0, s); wr(3'd1, b); wr(3'd2, p);
        wr(3'd6, 8'hFF);
        idle(1);
        pin_async = to;
        idle(4);
        rd(3'd4, v);
        check(req, v, expect_raw(s, b, p, from, to));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] froms [4];
        logic [7:0] tos [4];
        froms = '{8'h00, 8'hFF, 8'h0F, 8'hA5};
        tos   = '{8'hFF, 8'h00, 8'h3C, 8'h5A};
        idle(2);
        // R1: reset values
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v);
            check("R1 reset register", v, 8'h00);
        end
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R4 R5: all five modes against four transition patterns
        for (int t = 0; t < 4; t++) begin
            run_case("R2 level high", 8'hFF, 8'h00, 8'hFF, froms[t], tos[t]);
            run_case("R2 level low",  8'hFF, 8'h00, 8'h00, froms[t], tos[t]);
            run_case("R3 rising",     8'h00, 8'h00, 8'hFF, froms[t], tos[t]);
            run_case("R4 falling",    8'h00, 8'h00, 8'h00, froms[t], tos[t]);
            run_case("R5 any edge pol0", 8'h00, 8'hFF, 8'h00, froms[t], tos[t]);
            run_case("R5 any edge pol1", 8'h00, 8'hFF, 8'hFF, froms[t], tos[t]);
        end
        // mixed per-pin configuration
        run_case("R5 mixed modes", 8'hC0, 8'h30, 8'hAA, 8'h0F, 8'hF0);
        run_case("R5 mixed modes", 8'hC0, 8'h30, 8'hAA, 8'hF0, 8'h0F);

        // R10: register readback, read-only and write-only addresses
        wr(3'd3, 8'h5A); rd(3'd3, v); check("R10 enable readback", v, 8'h5A);
        wr(3'd2, 8'h3C); rd(3'd2, v); check("R10 polarity readback", v, 8'h3C);
        rd(3'd7, v); check("R10 level readback", v, 8'h0F);
        rd(3'd6, v); check("R10 clear reads zero", v, 8'h00);

        // edge rising on all pins, collect flags FF
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF);
        pin_async = 8'h00; idle(4); wr(3'd6, 8'hFF);
        pin_async = 8'hFF; idle(4);
        wr(3'd4, 8'h00); rd(3'd4, v); check("R10 raw ignores write", v, 8'hFF);

        // R6: masks
        begin
            logic [7:0] masks [5];
            masks = '{8'h00, 8'h01, 8'h80, 8'h5A, 8'hFF};
            for (int m = 0; m < 5; m++) begin
                wr(3'd3, masks[m]);
                rd(3'd5, v); check("R6 masked status", v, masks[m]);
                check("R6 irq", {7'd0, irq}, {7'd0, |masks[m]});
            end
        end

        // R7: partial clear, rest sticky
        wr(3'd6, 8'h0F); idle(3);
        rd(3'd4, v); check("R7 partial clear", v, 8'hF0);
        wr(3'd6, 8'hF0);
        rd(3'd4, v); check("R7 full clear", v, 8'h00);
        check("R7 irq low after clear", {7'd0, irq}, 8'h00);

        // R8: edge in same cycle as clear; any-edge mode, flags first set
        wr(3'd1, 8'hFF);
        pin_async = 8'h00; idle(4);
        rd(3'd4, v); check("R8 setup flags", v, 8'hFF);
        pin_async = 8'h0F;           // sampled at next edge k
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        wr(3'd6, 8'hFF);             // clear at edge k+2, where edge latches
        rd(3'd4, v); check("R8 collision keeps flag", v, 8'h0F);

        // R9: latency of edge and level paths
        wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd0, 8'h00);
        pin_async = 8'h00; idle(4); wr(3'd6, 8'hFF);
        bus_addr = 3'd4;
        pin_async = 8'hFF;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd4, v); check("R9 edge not before k+2", v, 8'h00);
        @(negedge clk);
        rd(3'd4, v); check("R9 edge after k+2", v, 8'hFF);
        wr(3'd0, 8'hFF);             // level high
        pin_async = 8'h00; idle(4);
        pin_async = 8'hFF;
        @(negedge clk);
        rd(3'd4, v); check("R9 level not before k+1", v, 8'h00);
        @(negedge clk);
        rd(3'd4, v); check("R9 level after k+1", v, 8'hFF);

        // R2: clear cannot remove a held level
        wr(3'd6, 8'hFF); idle(1);
        rd(3'd4, v); check("R2 level not clearable", v, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule